// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame should be kept, based on its 48-bit destination address. A request presents the address with a one-cycle valid strobe. The block answers with a one-cycle done strobe and an accept flag. The accept flag keeps its value until the next answer.

Group (multicast) addresses are checked against a 64-bin hash table. The block runs a bit-serial CRC-32 over the address, one bit per clock, and the top six bits of the result pick one bin. A host fills the table as four 16-bit words through a small write port.

Individual (unicast) addresses are compared against one programmed station address. Two mode inputs can widen acceptance. Promiscuous mode accepts everything. All-group mode accepts every multicast address without consulting the table. When the verdict does not need the hash, it is given at once.

Top module: `mhf_filter`

## Requirements
- R1: While and after reset, `busy`, `done` and `accept` are 0, and all 64 table bins are cleared.
- R2: When `promisc` is 1 at the sampling edge of a request, `accept` becomes 1 and `done` is high for the cycle that follows that edge (bypass timing). This holds for any address.
- R3: An address is multicast when `addr_in[0]` is 1. With `all_multi` at 1, a multicast request is accepted with bypass timing.
- R4: A non-multicast request without `promisc` is answered with bypass timing. `accept` is 1 exactly when `addr_in` equals `station_addr`, compared over all 48 bits.
- R5: The hash value is computed as follows. The CRC starts at 0xFFFFFFFF and takes 48 steps, with step s using `addr_in[s]` (byte k is `addr_in[8k+7:8k]`, least significant bit first). On each step, feedback is CRC bit 31 XOR the data bit. The CRC shifts left by one, and if feedback is 1 it is XORed with 0x04C11DB7.
- R6: For a multicast request with neither mode set, `accept` equals table word CRC[31:30], bit CRC[29:26], as that table holds when the result is produced.
- R7: With `tbl_wr_en` high at an edge, table word `tbl_wr_idx` takes `tbl_wr_data`. Bit b of that word is bin b of the word.
- R8: On the hash path, `busy` is high for the 48 cycles after the sampling edge. `done` is set on the 48th edge after the sampling edge, which is the same edge at which `busy` drops.
- R9: A valid strobe arriving while `busy` is high is ignored: it does not change the result of the running request and produces no extra answer.
- R10: `done` lasts one cycle for each request. `accept` changes only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_idx | input | 2 | Table word index |
| tbl_wr_data | input | 16 | Table word value |
| promisc | input | 1 | Accept-everything mode |
| all_multi | input | 1 | Accept-all-multicast mode |
| station_addr | input | 48 | Own unicast address |
| addr_valid | input | 1 | Request strobe |
| addr_in | input | 48 | Destination address of the request |
| busy | output | 1 | Hash computation in progress |
| done | output | 1 | Verdict strobe |
| accept | output | 1 | Verdict, held until the next strobe |

## Verification
The assertions check the properties that hold on every cycle:
- the bypass answers for promiscuous and unicast requests arrive one edge after sampling;
- the accept flag stays stable between strobes;
- a busy run never exceeds 48 cycles and always ends with a strobe.

The value of the CRC, the choice of hash bin, the ignoring of a request made while busy, and the reset-cleared table can only be shown by the bench's scenarios. Those scenarios sweep many multicast addresses against several table patterns and compare the results with a CRC computed independently in the bench.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int ADDR_W   = 48;
    localparam int CRC_W    = 32;
    localparam int WORD_W   = 16;
    localparam int N_WORDS  = 4;
    localparam int WSEL_W   = $clog2(N_WORDS);
    localparam int BSEL_W   = $clog2(WORD_W);
    localparam int HASH_W   = WSEL_W + BSEL_W;

    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;

    typedef enum logic [1:0] {
        PATH_NONE   = 2'd0,
        PATH_BYPASS = 2'd1,
        PATH_HASH   = 2'd2
    } path_e;

    typedef struct packed {
        logic hit;
        logic done;
    } verdict_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic d);
        logic fb;
        fb = c[CRC_W-1] ^ d;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic is_group(input logic [ADDR_W-1:0] a);
        return a[0];
    endfunction

endpackage

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
    parameter int N_WORDS = mhf_pkg::N_WORDS,
    parameter int WORD_W  = mhf_pkg::WORD_W,
    localparam int WSEL_W = $clog2(N_WORDS),
    localparam int BSEL_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WSEL_W-1:0] rd_word,
    input  logic [BSEL_W-1:0] rd_bit,
    output logic              hit
);

    logic [WORD_W-1:0] words [N_WORDS];

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[w] <= '0;
            end else if (wr_en && (wr_idx == WSEL_W'(w))) begin
                words[w] <= wr_data;
            end
        end
    end

    always_comb begin
        hit = words[rd_word][rd_bit];
    end

endmodule

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine #(
    parameter int DATA_W = mhf_pkg::ADDR_W,
    parameter int HASH_W = mhf_pkg::HASH_W,
    localparam int CNT_W = $clog2(DATA_W),
    localparam int CRC_W = mhf_pkg::CRC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              finish,
    output logic [HASH_W-1:0] hash
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_nxt;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;

    always_comb begin
        crc_nxt = mhf_pkg::crc_step(crc_q, data_q[cnt_q]);
        finish  = busy_q && (cnt_q == LAST);
        hash    = crc_nxt[CRC_W-1 -: HASH_W];
        busy    = busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= mhf_pkg::CRC_INIT;
            data_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start && !busy_q) begin
            crc_q  <= mhf_pkg::CRC_INIT;
            data_q <= data_in;
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            crc_q <= crc_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mhf_filter.sv
module mhf_filter #(
    parameter int ADDR_W  = mhf_pkg::ADDR_W,
    parameter int N_WORDS = mhf_pkg::N_WORDS,
    parameter int WORD_W  = mhf_pkg::WORD_W,
    localparam int WSEL_W = $clog2(N_WORDS),
    localparam int BSEL_W = $clog2(WORD_W),
    localparam int HASH_W = WSEL_W + BSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_wr_en,
    input  logic [WSEL_W-1:0] tbl_wr_idx,
    input  logic [WORD_W-1:0] tbl_wr_data,
    input  logic              promisc,
    input  logic              all_multi,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              busy,
    output logic              done,
    output logic              accept
);

    import mhf_pkg::*;

    logic              eng_busy;
    logic              eng_finish;
    logic [HASH_W-1:0] eng_hash;
    logic              tbl_hit;
    logic              take;
    path_e             path;
    verdict_t          bypass_v;
    logic              done_q;
    logic              accept_q;

    always_comb begin
        take = addr_valid && !eng_busy;
        path = PATH_NONE;
        bypass_v = '{hit: 1'b0, done: 1'b0};
        if (take) begin
            if (promisc) begin
                path = PATH_BYPASS;
                bypass_v = '{hit: 1'b1, done: 1'b1};
            end else if (!is_group(addr_in)) begin
                path = PATH_BYPASS;
                bypass_v = '{hit: (addr_in == station_addr), done: 1'b1};
            end else if (all_multi) begin
                path = PATH_BYPASS;
                bypass_v = '{hit: 1'b1, done: 1'b1};
            end else begin
                path = PATH_HASH;
            end
        end
    end

    mhf_crc_engine #(
        .DATA_W (ADDR_W),
        .HASH_W (HASH_W)
    ) u_crc (
        .clk     (clk),
        .rst     (rst),
        .start   (path == PATH_HASH),
        .data_in (addr_in),
        .busy    (eng_busy),
        .finish  (eng_finish),
        .hash    (eng_hash)
    );

    mhf_hash_table #(
        .N_WORDS (N_WORDS),
        .WORD_W  (WORD_W)
    ) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_data (tbl_wr_data),
        .rd_word (eng_hash[HASH_W-1 -: WSEL_W]),
        .rd_bit  (eng_hash[BSEL_W-1:0]),
        .hit     (tbl_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q   <= 1'b0;
            accept_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (path == PATH_BYPASS) begin
                done_q   <= bypass_v.done;
                accept_q <= bypass_v.hit;
            end else if (eng_finish) begin
                done_q   <= 1'b1;
                accept_q <= tbl_hit;
            end
        end
    end

    assign busy   = eng_busy;
    assign done   = done_q;
    assign accept = accept_q;

endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              promisc,
    input logic [ADDR_W-1:0] station_addr,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr_in,
    input logic              busy,
    input logic              done,
    input logic              accept
);

    logic [7:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    // R2
    promisc_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !busy && promisc) |=> (done && accept));

    // R4
    station_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !busy && !promisc && !addr_in[0])
        |=> (done && (accept == ($past(addr_in) == $past(station_addr)))));

    // R10
    accept_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(accept));

    // R8
    run_window_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < 8'(ADDR_W)));

    // R8
    run_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

bind mhf_filter mhf_filter_chk #(.ADDR_W(ADDR_W)) chk (
    .clk          (clk),
    .rst          (rst),
    .promisc      (promisc),
    .station_addr (station_addr),
    .addr_valid   (addr_valid),
    .addr_in      (addr_in),
    .busy         (busy),
    .done         (done),
    .accept       (accept)
);

// File: tb/mhf_filter_test.sv
`timescale 1ns/1ps
module mhf_filter_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        tbl_wr_en;
    logic [1:0]  tbl_wr_idx;
    logic [15:0] tbl_wr_data;
    logic        promisc;
    logic        all_multi;
    logic [47:0] station_addr;
    logic        addr_valid;
    logic [47:0] addr_in;
    logic        busy;
    logic        done;
    logic        accept;

    int vectors = 0;
    int errors  = 0;
    logic [15:0] tbl [4];
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    mhf_filter uut (
        .clk(clk), .rst(rst),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
        .promisc(promisc), .all_multi(all_multi), .station_addr(station_addr),
        .addr_valid(addr_valid), .addr_in(addr_in),
        .busy(busy), .done(done), .accept(accept)
    );

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c;
        logic carry;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            carry = c[31] ^ a[i];
            c = c << 1;
            if (carry) c = (c ^ 32'h04C1_1DB6) | 32'h1;
        end
        return c;
    endfunction

    function automatic logic ref_hit(input logic [47:0] a);
        logic [31:0] c;
        c = ref_crc(a);
        return tbl[c[31:30]][c[29:26]];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic next_rand(output logic [47:0] a);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        a = rng[47:0];
    endtask

    task automatic wr(input int idx, input logic [15:0] d);
        tbl_wr_en = 1'b1;
        tbl_wr_idx = 2'(idx);
        tbl_wr_data = d;
        tbl[idx] = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // issue one request, return edges-to-done count and verdict
    task automatic req(input logic [47:0] a, output int lat, output logic acc);
        addr_in = a;
        addr_valid = 1'b1;
        lat = 0;
        acc = 1'b0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            addr_valid = 1'b0;
            lat++;
            if (done) begin
                acc = accept;
                break;
            end
        end
        @(negedge clk);
        check("R10 done width", {63'd0, done}, 64'd0);
        check("R10 accept hold", {63'd0, accept}, {63'd0, acc});
    endtask

    task automatic expect_req(input string tag, input logic [47:0] a,
                              input int exp_lat, input logic exp_acc);
        int lat;
        logic acc;
        req(a, lat, acc);
        check({tag, " latency"}, 64'(lat), 64'(exp_lat));
        check({tag, " accept"}, {63'd0, acc}, {63'd0, exp_acc});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [47:0] a;
        int lat;
        logic acc;
        rst = 1'b1; tbl_wr_en = 1'b0; tbl_wr_idx = '0; tbl_wr_data = '0;
        promisc = 1'b0; all_multi = 1'b0; addr_valid = 1'b0; addr_in = '0;
        station_addr = 48'h1234_5678_9ABC;
        for (int w = 0; w < 4; w++) tbl[w] = 16'h0;
        repeat (3) @(negedge clk);
        check("R1 busy", {63'd0, busy}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 accept", {63'd0, accept}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1: cleared table rejects multicast addresses
        for (int i = 0; i < 8; i++) begin
            next_rand(a);
            expect_req("R1 R6 empty table", a | 48'h1, 49, 1'b0);
        end

        // R5 R6 R7 R8: sweep table patterns against many multicast addresses
        for (int p = 0; p < 8; p++) begin
            for (int w = 0; w < 4; w++) begin
                case (p)
                    0, 1, 2, 3: wr(w, (w == p) ? 16'hFFFF : 16'h0000);
                    4: wr(w, 16'hFFFF);
                    5: wr(w, 16'hA5C3 ^ (16'h1111 * 16'(w)));
                    6: wr(w, 16'h0001 << (w * 4 + 1));
                    default: wr(w, 16'h5A5A ^ 16'(w * 16'h0F0F));
                endcase
            end
            for (int i = 0; i < 48; i++) begin
                next_rand(a);
                a[0] = 1'b1;
                expect_req("R5 R6 R8 hash", a, 49, ref_hit(a));
            end
        end

        // R7: single-bit bins, one address per bin found by search
        for (int bin = 0; bin < 64; bin += 7) begin
            for (int w = 0; w < 4; w++) wr(w, 16'h0);
            wr(bin / 16, 16'h1 << (bin % 16));
            for (int i = 0; i < 4; i++) begin
                next_rand(a);
                a[0] = 1'b1;
                expect_req("R7 single bin", a, 49, ref_hit(a));
            end
        end

        // R3: all-multicast mode bypasses the empty table
        for (int w = 0; w < 4; w++) wr(w, 16'h0);
        all_multi = 1'b1;
        for (int i = 0; i < 6; i++) begin
            next_rand(a);
            expect_req("R3 all multicast", a | 48'h1, 1, 1'b1);
        end
        expect_req("R3 unicast unaffected", 48'h0000_0000_0002, 1, 1'b0);
        all_multi = 1'b0;

        // R4: station compare, equal and every single-bit difference
        expect_req("R4 station equal", station_addr, 1, 1'b1);
        for (int b = 1; b < 48; b++) begin
            expect_req("R4 station differ", station_addr ^ (48'h1 << b), 1, 1'b0);
        end

        // R2: promiscuous accepts unicast and multicast at bypass timing
        promisc = 1'b1;
        for (int i = 0; i < 6; i++) begin
            next_rand(a);
            expect_req("R2 promisc", a, 1, 1'b1);
        end
        promisc = 1'b0;

        // R9: a request during a run is ignored
        wr(0, 16'hFFFF); wr(1, 16'h0); wr(2, 16'hFFFF); wr(3, 16'h0);
        next_rand(a);
        a[0] = 1'b1;
        addr_in = a;
        addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
        check("R8 busy during run", {63'd0, busy}, 64'd1);
        repeat (4) @(negedge clk);
        addr_in = station_addr;
        promisc = 1'b1;
        addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
        promisc = 1'b0;
        check("R9 no early answer", {63'd0, done}, 64'd0);
        lat = 6;
        acc = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            lat++;
            if (done) begin
                acc = accept;
                break;
            end
        end
        check("R9 latency", 64'(lat), 64'd49);
        check("R9 accept", {63'd0, acc}, {63'd0, ref_hit(a)});
        repeat (3) begin
            @(negedge clk);
            check("R9 no extra answer", {63'd0, done}, 64'd0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule